// File: doc/BRIEF.md
# Edge-Latched Seven-Level Interrupt Requester

This block turns a set of event inputs into a single interrupt request on one of seven priority lines of a system bus. Eight sources (four channel limit crossings, an overload flag, a pretrigger-complete flag, a measurement-done flag and a trigger flag) are each caught on their rising edge by a pending latch. Each latch is gated by a per-source enable bit. The gated latches are ORed into one request, which is steered onto the line picked by a three-bit level code. A global enable bit must also be set for the request to reach that line.

Software sets one 16-bit control word. It reads back either that word or the pending latches through a one-bit read select. The bus interrupt-acknowledge cycle is given as a one-cycle strobe. That strobe clears every latch that is both set and enabled. Latches that are set but disabled stay pending. A source must fall and rise again before its latch can be set a second time. The data flow here is plain control and status with no stream, so no valid/ready handshake applies: the control write takes effect on the clock edge where the write strobe is high, and read data is a combinational view of the registers.

Top module: `irqc_top`

## Requirements
- R1: With control bits [2:0] holding a level code c from 1 to 7, an active request drives `irq_o[c-1]` high. No more than one bit of `irq_o` is ever high.
- R2: Level code 000 keeps every `irq_o` bit low, whatever the latches and enables hold.
- R3: Control bit 3 is the global enable. While it is 0, `irq_o` stays all low.
- R4: The request is the OR over all sources of (pending latch AND its enable bit). Enable bits sit at control bits [15:8].
- R5: A latch sets only on a 0-to-1 change of its input between two clock samples. A steady high level does not set it again after a clear. An input that is already high when reset ends does not set it.
- R6: An acknowledge strobe clears every latch that is set and enabled in that cycle. Set latches whose enable is 0 keep their value. A rising edge in the same cycle as the strobe leaves its latch set.
- R7: Source index i maps to `evt_i[i]`, to pending bit i and to enable bit 8+i. The order is: 0 channel 1, 1 channel 2, 2 channel 3, 3 channel 4, 4 overload, 5 pretrigger, 6 done, 7 trigger.
- R8: With `rd_sel_i`=0, `rd_data_o` returns the control word as written, with bits [7:4] always read as zero.
- R9: With `rd_sel_i`=1, `rd_data_o` returns the pending latches in bits [7:0], zero above. Reading does not change them. Latches set whether or not their enable bit is on.
- R10: An input rise sampled at clock edge k shows in the pending read after edge k and on `irq_o` after edge k+1. A control write at edge k shows on `irq_o` after edge k+1.
- R11: Reset clears the control word, the pending latches and `irq_o`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| evt_i | input | 8 | Event source inputs, index as in R7 |
| iack_i | input | 1 | Interrupt-acknowledge strobe, one cycle per acknowledge |
| ctrl_wr_i | input | 1 | Control word write strobe |
| ctrl_wdata_i | input | 16 | Control word write data |
| rd_sel_i | input | 1 | Read select: 0 control word, 1 pending latches |
| rd_data_o | output | 16 | Read data, combinational |
| irq_o | output | 7 | Interrupt lines, bit c-1 for level c, active high |

## Verification
Pending state is due one clock edge after the input edge is sampled. The `irq_o` lines are due one edge after that, because the line driver is registered. The read port has no latency. The bench drives inputs on the falling clock edge and checks on a later falling edge. In the vector walk it always lets at least two rising edges pass after the last stimulus before it compares pending bits and lines, so both latencies have run out. The directed latency test instead samples right after the first and the second rising edge. There it expects the pending bit set with `irq_o` still low, and then the line high.

// File: rtl/irqc_pkg.sv
package irqc_pkg;
  localparam int unsigned IRQC_N_SRC   = 8;
  localparam int unsigned IRQC_N_LVL   = 7;
  localparam int unsigned IRQC_REG_W   = 16;
  localparam int unsigned IRQC_GEN_BIT = 3;
  localparam int unsigned IRQC_EN_LSB  = 8;

  // source index order, also the enable-bit order from IRQC_EN_LSB upward (R7)
  typedef enum int unsigned {
    SRC_CH1  = 0,
    SRC_CH2  = 1,
    SRC_CH3  = 2,
    SRC_CH4  = 3,
    SRC_OVLD = 4,
    SRC_PRET = 5,
    SRC_DONE = 6,
    SRC_TRIG = 7
  } irqc_src_e;

  localparam logic RD_SEL_CTRL = 1'b0;
  localparam logic RD_SEL_PEND = 1'b1;
endpackage

// File: rtl/irqc_ctrl_reg.sv
module irqc_ctrl_reg #(
  parameter int unsigned REG_W   = 16,
  parameter int unsigned N_SRC   = 8,
  parameter int unsigned LVL_W   = 3,
  parameter int unsigned GEN_BIT = 3,
  parameter int unsigned EN_LSB  = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             wr_en_i,
  input  logic [REG_W-1:0] wr_data_i,
  output logic [LVL_W-1:0] lvl_o,
  output logic             glb_en_o,
  output logic [N_SRC-1:0] src_en_o,
  output logic [REG_W-1:0] rb_o
);
  localparam logic [REG_W-1:0] LVL_MASK = REG_W'((1 << LVL_W) - 1);
  localparam logic [REG_W-1:0] GEN_MASK = REG_W'(1) << GEN_BIT;
  localparam logic [REG_W-1:0] EN_MASK  = REG_W'((1 << N_SRC) - 1) << EN_LSB;
  localparam logic [REG_W-1:0] KEEP     = LVL_MASK | GEN_MASK | EN_MASK;

  logic [REG_W-1:0] word_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      word_q <= '0;
    else if (wr_en_i) word_q <= wr_data_i & KEEP;
  end

  assign lvl_o    = word_q[LVL_W-1:0];
  assign glb_en_o = word_q[GEN_BIT];
  assign src_en_o = word_q[EN_LSB +: N_SRC];
  assign rb_o     = word_q;

  // R8: unused bits never hold a one after any write
  p_rsvd_zero_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_en_i |=> (rb_o & ~KEEP) == '0);
  // R8: a write is returned on the following cycle for kept bits
  p_wr_readback_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_en_i |=> (rb_o == ($past(wr_data_i) & KEEP)));
endmodule

// File: rtl/irqc_src_latch.sv
module irqc_src_latch #(
  parameter int unsigned N_SRC = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [N_SRC-1:0] evt_i,
  input  logic [N_SRC-1:0] src_en_i,
  input  logic             iack_i,
  output logic [N_SRC-1:0] pend_o
);
  logic [N_SRC-1:0] prev_q;
  logic [N_SRC-1:0] pend_q;
  logic [N_SRC-1:0] rise_c;

  for (genvar i = 0; i < N_SRC; i++) begin : g_src
    logic clr_c;
    logic nxt_c;

    assign rise_c[i] = evt_i[i] & ~prev_q[i];
    assign clr_c     = iack_i & src_en_i[i] & pend_q[i];
    // a fresh edge wins over a same-cycle acknowledge
    assign nxt_c     = rise_c[i] | (pend_q[i] & ~clr_c);

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        prev_q[i] <= 1'b1;
        pend_q[i] <= 1'b0;
      end else begin
        prev_q[i] <= evt_i[i];
        pend_q[i] <= nxt_c;
      end
    end

    // R5: a latch only comes up after a sampled low-to-high input
    p_set_needs_edge_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
      $rose(pend_q[i]) |-> ($past(evt_i[i]) && !$past(prev_q[i])));
    // R5: every sampled rise is caught
    p_edge_caught_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
      rise_c[i] |=> pend_q[i]);
    // R6: acknowledge empties a set, enabled latch absent a new edge
    p_ack_clears_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (iack_i && pend_q[i] && src_en_i[i] && !rise_c[i]) |=> !pend_q[i]);
    // R6: acknowledge leaves a masked latch alone
    p_masked_kept_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (iack_i && pend_q[i] && !src_en_i[i]) |=> pend_q[i]);
    // R9: without acknowledge a set latch stays set
    p_hold_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (!iack_i && pend_q[i]) |=> pend_q[i]);
  end

  assign pend_o = pend_q;
endmodule

// File: rtl/irqc_lvl_drv.sv
module irqc_lvl_drv #(
  parameter int unsigned N_SRC = 8,
  parameter int unsigned N_LVL = 7,
  parameter int unsigned LVL_W = 3
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [N_SRC-1:0] pend_i,
  input  logic [N_SRC-1:0] src_en_i,
  input  logic             glb_en_i,
  input  logic [LVL_W-1:0] lvl_i,
  output logic [N_LVL-1:0] irq_o
);
  localparam logic [LVL_W-1:0] TOP_CODE = LVL_W'(N_LVL);

  logic             req_c;
  logic             arm_c;
  logic [N_LVL-1:0] irq_d;
  logic [N_LVL-1:0] irq_q;

  assign req_c = |(pend_i & src_en_i);
  assign arm_c = req_c & glb_en_i;

  for (genvar k = 0; k < N_LVL; k++) begin : g_line
    assign irq_d[k] = arm_c & (lvl_i == LVL_W'(k + 1));
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) irq_q <= '0;
    else         irq_q <= irq_d;
  end

  assign irq_o = irq_q;

  // R1: never more than one line
  p_one_line_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(irq_o));
  // R2: level code zero drives nothing
  p_lvl_zero_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (lvl_i == '0) |=> (irq_o == '0));
  // R3: global enable off drives nothing
  p_glb_off_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !glb_en_i |=> (irq_o == '0));
  // R4: an enabled pending source with a valid level raises a line
  p_req_line_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (|(pend_i & src_en_i) && glb_en_i && lvl_i != '0 && lvl_i <= TOP_CODE)
      |=> (irq_o != '0));
  // R4: no enabled pending source, no line
  p_no_req_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((pend_i & src_en_i) == '0) |=> (irq_o == '0));
endmodule

// File: rtl/irqc_top.sv
module irqc_top
  import irqc_pkg::*;
#(
  parameter int unsigned N_SRC   = IRQC_N_SRC,
  parameter int unsigned N_LVL   = IRQC_N_LVL,
  parameter int unsigned REG_W   = IRQC_REG_W,
  parameter int unsigned GEN_BIT = IRQC_GEN_BIT,
  parameter int unsigned EN_LSB  = IRQC_EN_LSB
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [N_SRC-1:0] evt_i,
  input  logic             iack_i,
  input  logic             ctrl_wr_i,
  input  logic [REG_W-1:0] ctrl_wdata_i,
  input  logic             rd_sel_i,
  output logic [REG_W-1:0] rd_data_o,
  output logic [N_LVL-1:0] irq_o
);
  localparam int unsigned LVL_W = $clog2(N_LVL + 1);

  logic [LVL_W-1:0] lvl;
  logic             glb_en;
  logic [N_SRC-1:0] src_en;
  logic [REG_W-1:0] ctrl_rb;
  logic [N_SRC-1:0] pend;

  irqc_ctrl_reg #(
    .REG_W(REG_W), .N_SRC(N_SRC), .LVL_W(LVL_W),
    .GEN_BIT(GEN_BIT), .EN_LSB(EN_LSB)
  ) u_ctrl (
    .clk_i(clk_i), .rst_ni(rst_ni),
    .wr_en_i(ctrl_wr_i), .wr_data_i(ctrl_wdata_i),
    .lvl_o(lvl), .glb_en_o(glb_en), .src_en_o(src_en), .rb_o(ctrl_rb)
  );

  irqc_src_latch #(.N_SRC(N_SRC)) u_latch (
    .clk_i(clk_i), .rst_ni(rst_ni),
    .evt_i(evt_i), .src_en_i(src_en), .iack_i(iack_i),
    .pend_o(pend)
  );

  irqc_lvl_drv #(.N_SRC(N_SRC), .N_LVL(N_LVL), .LVL_W(LVL_W)) u_drv (
    .clk_i(clk_i), .rst_ni(rst_ni),
    .pend_i(pend), .src_en_i(src_en), .glb_en_i(glb_en), .lvl_i(lvl),
    .irq_o(irq_o)
  );

  assign rd_data_o = (rd_sel_i == RD_SEL_PEND) ? REG_W'(pend) : ctrl_rb;

  // R9: the status view carries nothing above the source bits
  p_pend_view_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_sel_i == RD_SEL_PEND) |-> ((rd_data_o >> N_SRC) == '0));
endmodule

// File: tb/irqc_top_tb_top.sv
`timescale 1ns/1ps
module irqc_top_tb_top;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic [7:0]  evt_i = '0;
  logic        iack_i = 1'b0;
  logic        ctrl_wr_i = 1'b0;
  logic [15:0] ctrl_wdata_i = '0;
  logic        rd_sel_i = 1'b0;
  logic [15:0] rd_data_o;
  logic [6:0]  irq_o;

  int n_chk = 0;
  int n_err = 0;

  always #2 clk_i = ~clk_i;

  irqc_top dut_i (
    .clk_i(clk_i), .rst_ni(rst_ni), .evt_i(evt_i), .iack_i(iack_i),
    .ctrl_wr_i(ctrl_wr_i), .ctrl_wdata_i(ctrl_wdata_i),
    .rd_sel_i(rd_sel_i), .rd_data_o(rd_data_o), .irq_o(irq_o)
  );

  // {ctrl[39:24], evt[23:16], iack[15], exp_pend[14:7], exp_irq[6:0]}
  localparam int NV = 10;
  localparam logic [39:0] VECS [0:NV-1] = '{
    {16'h0009, 8'h01, 1'b0, 8'h01, 7'h00},  // R4 latched but not enabled
    {16'h010B, 8'h00, 1'b0, 8'h01, 7'h04},  // R1 level 3
    {16'h0103, 8'h00, 1'b0, 8'h01, 7'h00},  // R3 global off
    {16'h0108, 8'h00, 1'b0, 8'h01, 7'h00},  // R2 level 0
    {16'h010F, 8'h00, 1'b0, 8'h01, 7'h40},  // R1 level 7
    {16'h010F, 8'h00, 1'b1, 8'h00, 7'h00},  // R6 acknowledge
    {16'hF00D, 8'h12, 1'b1, 8'h02, 7'h00},  // R6 masked ch2 kept
    {16'h020D, 8'h00, 1'b0, 8'h02, 7'h10},  // R4 level 5
    {16'h800A, 8'h80, 1'b0, 8'h82, 7'h02},  // R7 trigger level 2
    {16'hFF0E, 8'h00, 1'b1, 8'h00, 7'h00}   // R6 all cleared
  };

  task automatic step();
    @(posedge clk_i);
    @(negedge clk_i);
  endtask

  task automatic chk(input string tag, input logic [15:0] got, input logic [15:0] exp);
    n_chk++;
    if (got !== exp) begin
      n_err++;
      $display("FAIL %s got %h exp %h", tag, got, exp);
    end
  endtask

  task automatic rd(input logic sel, output logic [15:0] val);
    rd_sel_i = sel;
    #0.5;
    val = rd_data_o;
  endtask

  task automatic wr(input logic [15:0] w);
    ctrl_wr_i = 1'b1;
    ctrl_wdata_i = w;
    step();
    ctrl_wr_i = 1'b0;
  endtask

  initial begin
    #400000;
    n_err++;
    $display("FAIL watchdog expired");
    $display("CHECKS %0d ERRORS %0d", n_chk, n_err);
    $finish;
  end

  initial begin
    logic [15:0] v;
    @(negedge clk_i);
    @(negedge clk_i);
    // R11 reset state
    rd(1'b0, v); chk("R11 ctrl at reset", v, 16'h0000);
    rd(1'b1, v); chk("R11 pend at reset", v, 16'h0000);
    chk("R11 irq at reset", {9'd0, irq_o}, 16'h0000);
    rst_ni = 1'b1;
    step();

    for (int n = 0; n < NV; n++) begin
      logic [39:0] vec;
      vec = VECS[n];
      ctrl_wr_i = 1'b1; ctrl_wdata_i = vec[39:24]; evt_i = vec[23:16];
      step();
      ctrl_wr_i = 1'b0; iack_i = vec[15];
      step();
      iack_i = 1'b0;
      step();
      step();
      rd(1'b1, v);
      chk($sformatf("R4/R6/R9 vec %0d pend", n), v, {8'd0, vec[14:7]});
      chk($sformatf("R1/R2/R3 vec %0d irq", n), {9'd0, irq_o}, {9'd0, vec[6:0]});
      evt_i = '0;
      step();
    end

    // R8 reserved bits read zero
    wr(16'hFFFF);
    rd(1'b0, v); chk("R8 readback", v, 16'hFF0F);

    // R10 latency, R7 channel 3 maps to bit 2
    evt_i = 8'h04;
    step();
    rd(1'b1, v); chk("R10 pend after first edge", v, 16'h0004);
    chk("R10 irq not yet", {9'd0, irq_o}, 16'h0000);
    step();
    chk("R10 irq after second edge", {9'd0, irq_o}, 16'h0040);

    // R5 steady high does not set again
    iack_i = 1'b1; step(); iack_i = 1'b0;
    step(); step();
    rd(1'b1, v); chk("R5 steady high no reset", v, 16'h0000);
    chk("R5 irq quiet", {9'd0, irq_o}, 16'h0000);

    // R9 masked source still latches; read is non-clearing
    wr(16'h000F);
    evt_i = 8'h84;
    step(); step();
    rd(1'b1, v); chk("R9 pend first read", v, 16'h0080);
    rd(1'b1, v); chk("R9 pend second read", v, 16'h0080);
    chk("R4 masked gives no irq", {9'd0, irq_o}, 16'h0000);
    iack_i = 1'b1; step(); iack_i = 1'b0;
    rd(1'b1, v); chk("R6 masked kept on ack", v, 16'h0080);
    wr(16'h800F);
    step();
    chk("R4 enable raises irq", {9'd0, irq_o}, 16'h0040);

    // R6 edge in the ack cycle wins
    evt_i = 8'h04; step();
    evt_i = 8'h84; iack_i = 1'b1; step(); iack_i = 1'b0;
    rd(1'b1, v); chk("R6 edge beats ack", v, 16'h0080);

    // R7 overload at bit 4, enable bit 12
    iack_i = 1'b1; step(); iack_i = 1'b0;
    wr(16'h100A);
    evt_i = 8'h00; step();
    evt_i = 8'h10; step(); step();
    rd(1'b1, v); chk("R7 overload pend", v, 16'h0010);
    chk("R7 overload irq level 2", {9'd0, irq_o}, 16'h0002);

    // R11/R5 reset with inputs high
    rst_ni = 1'b0; evt_i = 8'hFF;
    step(); step();
    rd(1'b0, v); chk("R11 ctrl cleared", v, 16'h0000);
    rst_ni = 1'b1;
    step(); step();
    rd(1'b1, v); chk("R5 high at reset exit no set", v, 16'h0000);
    chk("R11 irq cleared", {9'd0, irq_o}, 16'h0000);

    $display("CHECKS %0d ERRORS %0d", n_chk, n_err);
    $finish;
  end
endmodule